// File: doc/BRIEF.md
# Downward-Growing LIFO Stack Controller

This block keeps a last-in first-out stack in a small register file that it owns. A stack pointer starts at the bottom value, which is one past the highest storage address. Each accepted push first moves the pointer down by one and then stores the incoming word at the new pointer. Each accepted pop loads the word at the pointer into an output data register and then moves the pointer up by one. Two flags report the boundaries. The stack is full when the pointer has reached address 0, and it is empty when the pointer is back at the bottom value.

A request that cannot be served is refused: a push while full, a pop while empty, or a push and a pop in the same cycle. A refused request changes neither the pointer, nor the storage, nor the output register. Instead the block raises a one-cycle error pulse. A client drives at most one request per cycle and reads the popped word on the data output from the cycle after the pop.

Top module: `lifo_stack`

## Requirements
- R1: After reset, stackEmpty is 1, stackFull is 0, opError is 0 and popData is 0.
- R2: An accepted push (pushReq=1, popReq=0, stackFull=0) clears stackEmpty and leaves opError at 0 in the following cycle.
- R3: Words leave in last-in first-out order. The word taken by an accepted pop appears on popData in the cycle after the pop and is held there until the next accepted pop.
- R4: With the default DEPTH of 11, stackFull rises in the cycle after the eleventh push from empty, and it stays 0 after ten pushes.
- R5: A push while stackFull is 1 raises opError for the following cycle, keeps stackFull at 1 and stores nothing. The next pop still returns the eleventh accepted word.
- R6: A pop while stackEmpty is 1 raises opError for the following cycle, keeps stackEmpty at 1 and leaves popData unchanged.
- R7: pushReq and popReq together raise opError for the following cycle. Flags, popData and stored contents are unchanged.
- R8: An accepted pop clears stackFull. stackEmpty is set in the cycle after the pop that removes the last word.
- R9: opError is high only in the cycle after a refused request. A refused request followed by an idle cycle gives a pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushReq | input | 1 | Request to push pushData |
| popReq | input | 1 | Request to pop into popData |
| pushData | input | DATA_W | Word to be pushed |
| popData | output | DATA_W | Data register holding the last popped word |
| stackFull | output | 1 | Pointer at address 0 |
| stackEmpty | output | 1 | Pointer at bottom value DEPTH |
| opError | output | 1 | One-cycle pulse for a refused request |

## Verification
All four outputs are registered. A request presented before a rising edge therefore shows its effect one cycle later: updated flags, the error pulse and the popped word are all due after the next edge. The bench drives each request on a falling edge and samples on the following falling edge, one full edge after the update. To check that a refused request changed nothing, the bench reads the flags at once and then drains the stack by popping, comparing every word with a model queue kept in the bench.

// File: rtl/lifo_stack_pkg.sv
package lifo_stack_pkg;
  typedef struct packed {
    logic doPush;
    logic doPop;
  } stackStrobes_t;
endpackage

// File: rtl/lifo_stack_ctrl.sv
module lifo_stack_ctrl
  import lifo_stack_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushReq,
  input  logic          popReq,
  input  logic          nextPushHitsTop,
  input  logic          nextPopHitsBottom,
  output stackStrobes_t strobes,
  output logic          stackFull,
  output logic          stackEmpty,
  output logic          opError
);
  logic bothReq;
  logic pushOk;
  logic popOk;
  logic refused;

  always_comb begin
    bothReq = pushReq && popReq;
    pushOk  = pushReq && !popReq && !stackFull;
    popOk   = popReq && !pushReq && !stackEmpty;
    refused = (pushReq || popReq) && !pushOk && !popOk;
    strobes.doPush = pushOk;
    strobes.doPop  = popOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackFull  <= 1'b0;
      stackEmpty <= 1'b1;
      opError    <= 1'b0;
    end else begin
      opError <= refused || bothReq;
      if (pushOk) begin
        stackFull  <= nextPushHitsTop;
        stackEmpty <= 1'b0;
      end else if (popOk) begin
        stackEmpty <= nextPopHitsBottom;
        stackFull  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lifo_stack_dp.sv
module lifo_stack_dp
  import lifo_stack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackStrobes_t     strobes,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData,
  output logic              nextPushHitsTop,
  output logic              nextPopHitsBottom
);
  localparam int SP_W = $clog2(DEPTH + 1);
  localparam logic [SP_W-1:0] SP_BOTTOM = SP_W'(DEPTH);

  logic [SP_W-1:0]   stackPtr;
  logic [SP_W-1:0]   writeAddr;
  logic [DATA_W-1:0] entries [DEPTH];
  logic [DATA_W-1:0] readWord;

  assign writeAddr         = stackPtr - SP_W'(1);
  assign nextPushHitsTop   = (stackPtr == SP_W'(1));
  assign nextPopHitsBottom = (stackPtr == SP_W'(DEPTH - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackPtr <= SP_BOTTOM;
    end else if (strobes.doPush) begin
      stackPtr <= writeAddr;
    end else if (strobes.doPop) begin
      stackPtr <= stackPtr + SP_W'(1);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strobes.doPush && (writeAddr == SP_W'(i))) begin
        entries[i] <= pushData;
      end
    end
  end

  always_comb begin
    readWord = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (stackPtr == SP_W'(i)) readWord = entries[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      popData <= '0;
    end else if (strobes.doPop) begin
      popData <= readWord;
    end
  end
endmodule

// File: rtl/lifo_stack.sv
module lifo_stack
  import lifo_stack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData,
  output logic              stackFull,
  output logic              stackEmpty,
  output logic              opError
);
  stackStrobes_t strobes;
  logic nextPushHitsTop;
  logic nextPopHitsBottom;

  lifo_stack_ctrl u_ctrl (
    .clk               (clk),
    .rstN              (rstN),
    .pushReq           (pushReq),
    .popReq            (popReq),
    .nextPushHitsTop   (nextPushHitsTop),
    .nextPopHitsBottom (nextPopHitsBottom),
    .strobes           (strobes),
    .stackFull         (stackFull),
    .stackEmpty        (stackEmpty),
    .opError           (opError)
  );

  lifo_stack_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk               (clk),
    .rstN              (rstN),
    .strobes           (strobes),
    .pushData          (pushData),
    .popData           (popData),
    .nextPushHitsTop   (nextPushHitsTop),
    .nextPopHitsBottom (nextPopHitsBottom)
  );
endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushReq,
  input logic              popReq,
  input logic [DATA_W-1:0] popData,
  input logic              stackFull,
  input logic              stackEmpty,
  input logic              opError
);
  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(stackFull && stackEmpty));

  p_push_clears_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && !stackFull) |=> (!stackEmpty && !opError));

  p_full_push_refused_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && stackFull) |=> (opError && stackFull && $stable(popData)));

  p_empty_pop_refused_r6: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && stackEmpty) |=> (opError && stackEmpty && $stable(popData)));

  p_both_refused_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq) |=> (opError && $stable(stackFull) && $stable(stackEmpty)
                             && $stable(popData)));

  p_pop_clears_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && !stackEmpty) |=> (!stackFull && !opError));

  p_error_has_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opError) |-> $past((pushReq && popReq) || (pushReq && stackFull)
                             || (popReq && stackEmpty)));
endmodule

bind lifo_stack lifo_stack_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pushReq    (pushReq),
  .popReq     (popReq),
  .popData    (popData),
  .stackFull  (stackFull),
  .stackEmpty (stackEmpty),
  .opError    (opError)
);

// File: tb/tb_lifo_stack.sv
module tb_lifo_stack;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              pushReq = 1'b0;
  logic              popReq = 1'b0;
  logic [DATA_W-1:0] pushData = '0;
  logic [DATA_W-1:0] popData;
  logic              stackFull;
  logic              stackEmpty;
  logic              opError;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] model [$];

  always #10 clk = ~clk;

  lifo_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .pushData(pushData), .popData(popData), .stackFull(stackFull),
    .stackEmpty(stackEmpty), .opError(opError)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic doPush, input logic doPop, input logic [DATA_W-1:0] d);
    pushReq  = doPush;
    popReq   = doPop;
    pushData = d;
    @(negedge clk);
    pushReq = 1'b0;
    popReq  = 1'b0;
  endtask

  task automatic pushWord(input logic [DATA_W-1:0] d);
    step(1'b1, 1'b0, d);
    model.push_back(d);
  endtask

  task automatic popExpect(input string req);
    logic [DATA_W-1:0] exp;
    exp = model.pop_back();
    step(1'b0, 1'b1, '0);
    check(req, popData, exp);
    check(req, opError, 1'b0);
  endtask

  task automatic test_reset();
    check("R1 empty", stackEmpty, 1'b1);
    check("R1 full", stackFull, 1'b0);
    check("R1 err", opError, 1'b0);
    check("R1 data", popData, 0);
  endtask

  task automatic test_basic_lifo();
    pushWord(8'h3A);
    check("R2 empty cleared", stackEmpty, 1'b0);
    check("R2 no err", opError, 1'b0);
    pushWord(8'h51);
    pushWord(8'hC7);
    popExpect("R3 last in");
    @(negedge clk);
    check("R3 data held", popData, 8'hC7);
    popExpect("R3 second");
    pushWord(8'h09);
    popExpect("R3 interleaved");
    check("R8 not yet empty", stackEmpty, 1'b0);
    popExpect("R3 first in");
    check("R8 empty after last", stackEmpty, 1'b1);
  endtask

  task automatic test_empty_pop();
    step(1'b0, 1'b1, '0);
    check("R6 err", opError, 1'b1);
    check("R6 still empty", stackEmpty, 1'b1);
    check("R6 data kept", popData, 8'h3A);
    @(negedge clk);
    check("R9 pulse ends", opError, 1'b0);
  endtask

  task automatic test_fill_and_overflow();
    for (int i = 0; i < DEPTH; i++) begin
      pushWord(DATA_W'(8'h10 + i));
      if (i == DEPTH - 2) check("R4 not full at ten", stackFull, 1'b0);
    end
    check("R4 full at eleven", stackFull, 1'b1);
    step(1'b1, 1'b0, 8'hEE);
    check("R5 err", opError, 1'b1);
    check("R5 still full", stackFull, 1'b1);
    step(1'b1, 1'b1, 8'hDD);
    check("R7 err", opError, 1'b1);
    check("R7 full kept", stackFull, 1'b1);
    check("R7 data kept", popData, 8'h3A);
    popExpect("R5 top is eleventh word");
    check("R8 full cleared", stackFull, 1'b0);
    while (model.size() > 0) popExpect("R3 drain order");
    check("R8 empty after drain", stackEmpty, 1'b1);
  endtask

  task automatic test_both_when_empty();
    step(1'b1, 1'b1, 8'h77);
    check("R7 err on empty", opError, 1'b1);
    check("R7 stays empty", stackEmpty, 1'b1);
    @(negedge clk);
    check("R9 single pulse", opError, 1'b0);
    check("R7 nothing stored", stackEmpty, 1'b1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_basic_lifo();
    test_empty_pop();
    test_fill_and_overflow();
    test_both_when_empty();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule